// File: doc/BRIEF.md
# Two-Level Cache Tuning Sequencer

This block searches the configuration space of a two-level cache hierarchy for a low-energy setting without visiting every point. It holds six configuration fields: size, line size and associativity for the first level and for the second level. Each field is an index in which 0 is the smallest legal value. Once started, the block drives a candidate configuration and raises an evaluation request. An external measurement unit answers with a 32-bit energy figure and a one-cycle valid strobe. The block then keeps or undoes the last change and moves on.

The search handles one parameter at a time in a fixed interleaved order: first-level size, second-level size, first-level line size, second-level line size, first-level associativity, second-level associativity. It first measures the all-smallest configuration. For each parameter it then raises the index by one per trial. It stops on that parameter at the first trial that is not strictly cheaper than the best so far, and that trial is undone. It also stops when the index reaches its largest value. After the sixth parameter the best configuration stays on the outputs and a done flag is raised. The instruction hierarchy and the data hierarchy are each tuned by a separate start of the block. With the default field ranges the space holds 216 points, and the search measures at most 10 of them.

Top module: `cache_tune_seq`

## Requirements
- R1: After reset all six configuration outputs are 0, `eval_req` and `done` are low and `eval_count` is 0.
- R2: A `start` pulse while idle or done clears `eval_count` and, one clock later, raises `eval_req` with all six fields at 0. `start` is ignored while a search is running.
- R3: Parameters are tuned in the order first-level size, second-level size, first-level line, second-level line, first-level ways, second-level ways. Each trial after the first differs from the best configuration so far in exactly one field, and that field is one index higher.
- R4: A trial whose energy is strictly lower than the best so far becomes the new best, and the same parameter is tried one step higher. An equal or higher energy restores that field to its previous index and ends the parameter.
- R5: A parameter whose index has reached its largest value (field range minus one) is not raised further, and the search moves to the next parameter.
- R6: `eval_req` and the configuration outputs stay unchanged until `energy_valid` arrives. `energy_valid` has no effect while `eval_req` is low.
- R7: When the last parameter is finished, `done` goes high with the best configuration on the outputs and `eval_req` low. Both stay so until `start` or `abort`.
- R8: `abort` in any state returns the block to idle on the next clock: all fields are 0 and `done` and `eval_req` are low. `abort` takes priority over `energy_valid` and `start` in the same cycle, and an energy presented together with `abort` is not counted.
- R9: `eval_count` increments by one for each energy accepted during `eval_req` and holds otherwise.
- R10: The number of trials in one search never exceeds one plus the sum over the six fields of (range − 1), which is 10 with the default ranges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (idle or done only) |
| abort | input | 1 | Return to idle with all-zero configuration |
| energy_valid | input | 1 | Energy result strobe |
| energy | input | 32 | Unsigned energy of the configuration on the outputs |
| eval_req | output | 1 | Request to measure the current configuration |
| l1_size | output | IDX_W | First-level size index |
| l1_line | output | IDX_W | First-level line size index |
| l1_ways | output | IDX_W | First-level associativity index |
| l2_size | output | IDX_W | Second-level size index |
| l2_line | output | IDX_W | Second-level line size index |
| l2_ways | output | IDX_W | Second-level associativity index |
| done | output | 1 | Search finished, best configuration applied |
| eval_count | output | CNT_W | Number of energies accepted in this search |

## Verification
Abort and acceptance of a measurement can fall in the same cycle: an energy strobe that arrives while the request is pending competes with an abort that would throw the search away. The bench waits for the second trial request and then drives `energy_valid` and `abort` together at that edge. It judges the result on the next cycle: the request must be low, all fields must be zero, `done` must be low and the trial counter must still show only the one earlier result. A second case drives `start` and `abort` together while idle and requires that no request follows.

// File: rtl/cache_tune_pkg.sv
package cache_tune_pkg;

    localparam int ENERGY_W  = 32;
    localparam int NUM_STEPS = 6;

    // Step positions, in tuning order; the sequence is behaviour.
    localparam int STEP_L1_SIZE = 0;
    localparam int STEP_L2_SIZE = 1;
    localparam int STEP_L1_LINE = 2;
    localparam int STEP_L2_LINE = 3;
    localparam int STEP_L1_WAYS = 4;
    localparam int STEP_L2_WAYS = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EVAL,
        ST_NEXT,
        ST_DONE
    } tune_state_e;

    typedef enum logic [1:0] {
        CFG_KEEP,
        CFG_CLEAR,
        CFG_BUMP,
        CFG_BACK
    } cfg_op_e;

    // Worst-case trial count: the base point plus one trial per step up.
    function automatic int trial_budget(int a, int b, int c, int d, int e, int f);
        return 1 + (a - 1) + (b - 1) + (c - 1) + (d - 1) + (e - 1) + (f - 1);
    endfunction

endpackage

// File: rtl/cache_tune_cfg.sv
module cache_tune_cfg
    import cache_tune_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int NUM   = NUM_STEPS,
    parameter int SEL_W = $clog2(NUM + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  cfg_op_e                   op,
    input  logic [SEL_W-1:0]          sel,
    output logic [NUM-1:0][IDX_W-1:0] fields
);

    for (genvar g = 0; g < NUM; g++) begin : g_field
        logic hit;
        assign hit = (sel == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                fields[g] <= '0;
            end else begin
                unique case (op)
                    CFG_CLEAR: fields[g] <= '0;
                    CFG_BUMP:  if (hit) fields[g] <= fields[g] + IDX_W'(1);
                    CFG_BACK:  if (hit) fields[g] <= fields[g] - IDX_W'(1);
                    default:   ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cache_tune_best.sv
module cache_tune_best
    import cache_tune_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [ENERGY_W-1:0] energy,
    output logic                better
);

    logic [ENERGY_W-1:0] best_q;

    assign better = (energy < best_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            best_q <= '1;
        end else if (load) begin
            best_q <= energy;
        end
    end

endmodule

// File: rtl/cache_tune_count.sv
module cache_tune_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/cache_tune_seq.sv
module cache_tune_seq
    import cache_tune_pkg::*;
#(
    parameter int IDX_W     = 2,
    parameter int L1_SIZE_N = 3,
    parameter int L1_LINE_N = 3,
    parameter int L1_WAYS_N = 3,
    parameter int L2_SIZE_N = 2,
    parameter int L2_LINE_N = 2,
    parameter int L2_WAYS_N = 2,
    parameter int MAX_TRIALS = trial_budget(L1_SIZE_N, L2_SIZE_N, L1_LINE_N,
                                            L2_LINE_N, L1_WAYS_N, L2_WAYS_N),
    parameter int CNT_W     = $clog2(MAX_TRIALS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                abort,
    input  logic                energy_valid,
    input  logic [ENERGY_W-1:0] energy,
    output logic                eval_req,
    output logic [IDX_W-1:0]    l1_size,
    output logic [IDX_W-1:0]    l1_line,
    output logic [IDX_W-1:0]    l1_ways,
    output logic [IDX_W-1:0]    l2_size,
    output logic [IDX_W-1:0]    l2_line,
    output logic [IDX_W-1:0]    l2_ways,
    output logic                done,
    output logic [CNT_W-1:0]    eval_count
);

    localparam int STEP_W = $clog2(NUM_STEPS + 1);

    // Largest index of each field, laid out in tuning order (index 0 first).
    localparam logic [NUM_STEPS-1:0][IDX_W-1:0] LAST = {
        IDX_W'(L2_WAYS_N - 1), IDX_W'(L1_WAYS_N - 1),
        IDX_W'(L2_LINE_N - 1), IDX_W'(L1_LINE_N - 1),
        IDX_W'(L2_SIZE_N - 1), IDX_W'(L1_SIZE_N - 1)
    };

    tune_state_e                      state_q, state_d;
    logic [STEP_W-1:0]                step_q,  step_d;
    logic                             first_q, first_d;
    cfg_op_e                          cfg_op;
    logic [NUM_STEPS-1:0][IDX_W-1:0]  fields;
    logic                             best_load;
    logic                             better;
    logic                             cnt_clr;
    logic                             cnt_inc;
    logic                             steps_over;
    logic                             at_last;

    assign steps_over = (step_q == STEP_W'(NUM_STEPS));
    assign at_last    = steps_over ? 1'b1 : (fields[step_q] == LAST[step_q]);

    always_comb begin
        state_d   = state_q;
        step_d    = step_q;
        first_d   = first_q;
        cfg_op    = CFG_KEEP;
        best_load = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;

        if (abort) begin
            state_d = ST_IDLE;
            step_d  = '0;
            first_d = 1'b0;
            cfg_op  = CFG_CLEAR;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state_d = ST_EVAL;
                        step_d  = '0;
                        first_d = 1'b1;
                        cfg_op  = CFG_CLEAR;
                        cnt_clr = 1'b1;
                    end
                end
                ST_EVAL: begin
                    if (energy_valid) begin
                        cnt_inc = 1'b1;
                        first_d = 1'b0;
                        state_d = ST_NEXT;
                        if (first_q || better) begin
                            best_load = 1'b1;
                        end else begin
                            cfg_op = CFG_BACK;
                            step_d = step_q + STEP_W'(1);
                        end
                    end
                end
                ST_NEXT: begin
                    if (steps_over) begin
                        state_d = ST_DONE;
                    end else if (at_last) begin
                        step_d = step_q + STEP_W'(1);
                    end else begin
                        cfg_op  = CFG_BUMP;
                        state_d = ST_EVAL;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            first_q <= first_d;
        end
    end

    cache_tune_cfg #(
        .IDX_W (IDX_W),
        .NUM   (NUM_STEPS),
        .SEL_W (STEP_W)
    ) i_cfg (
        .clk    (clk),
        .rst    (rst),
        .op     (cfg_op),
        .sel    (step_q),
        .fields (fields)
    );

    cache_tune_best i_best (
        .clk    (clk),
        .rst    (rst),
        .load   (best_load),
        .energy (energy),
        .better (better)
    );

    cache_tune_count #(
        .CNT_W (CNT_W)
    ) i_count (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clr),
        .inc   (cnt_inc),
        .count (eval_count)
    );

    assign eval_req = (state_q == ST_EVAL);
    assign done     = (state_q == ST_DONE);
    assign l1_size  = fields[STEP_L1_SIZE];
    assign l2_size  = fields[STEP_L2_SIZE];
    assign l1_line  = fields[STEP_L1_LINE];
    assign l2_line  = fields[STEP_L2_LINE];
    assign l1_ways  = fields[STEP_L1_WAYS];
    assign l2_ways  = fields[STEP_L2_WAYS];

endmodule

// File: rtl/cache_tune_seq_chk.sv
module cache_tune_seq_chk #(
    parameter int IDX_W      = 2,
    parameter int L1_SIZE_N  = 3,
    parameter int L1_LINE_N  = 3,
    parameter int L1_WAYS_N  = 3,
    parameter int L2_SIZE_N  = 2,
    parameter int L2_LINE_N  = 2,
    parameter int L2_WAYS_N  = 2,
    parameter int MAX_TRIALS = 10,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             abort,
    input logic             energy_valid,
    input logic             eval_req,
    input logic [IDX_W-1:0] l1_size,
    input logic [IDX_W-1:0] l1_line,
    input logic [IDX_W-1:0] l1_ways,
    input logic [IDX_W-1:0] l2_size,
    input logic [IDX_W-1:0] l2_line,
    input logic [IDX_W-1:0] l2_ways,
    input logic             done,
    input logic [CNT_W-1:0] eval_count
);

    logic [6*IDX_W-1:0] cfg_bus;
    assign cfg_bus = {l2_ways, l1_ways, l2_line, l1_line, l2_size, l1_size};

    // R6: a pending request and its configuration hold until answered.
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        eval_req && !energy_valid && !abort |=> eval_req && $stable(cfg_bus));

    // R7: the finished state never requests a measurement.
    p_done_no_req_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !eval_req);

    // R7: done and the applied configuration persist without start/abort.
    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        done && !start && !abort |=> done && $stable(cfg_bus));

    // R8: abort lands in idle with the smallest configuration.
    p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
        abort |=> !eval_req && !done && (cfg_bus == '0));

    // R8: an energy presented with abort is not counted.
    p_abort_nocount_r8: assert property (@(posedge clk) disable iff (rst)
        abort && !$isunknown(eval_count) |=> $stable(eval_count));

    // R9: an accepted energy advances the counter by one.
    p_count_inc_r9: assert property (@(posedge clk) disable iff (rst)
        eval_req && energy_valid && !abort |=>
            eval_count == $past(eval_count) + CNT_W'(1));

    // R2: restart from done begins at the all-smallest point.
    p_restart_zero_r2: assert property (@(posedge clk) disable iff (rst)
        done && start && !abort |=> eval_req && (cfg_bus == '0) && (eval_count == '0));

    // R5: no field ever exceeds its largest index.
    p_field_limit_r5: assert property (@(posedge clk) disable iff (rst)
        (int'(l1_size) < L1_SIZE_N) && (int'(l2_size) < L2_SIZE_N) &&
        (int'(l1_line) < L1_LINE_N) && (int'(l2_line) < L2_LINE_N) &&
        (int'(l1_ways) < L1_WAYS_N) && (int'(l2_ways) < L2_WAYS_N));

    // R10: the trial count stays within the search budget.
    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        int'(eval_count) <= MAX_TRIALS);

endmodule

bind cache_tune_seq cache_tune_seq_chk #(
    .IDX_W      (IDX_W),
    .L1_SIZE_N  (L1_SIZE_N),
    .L1_LINE_N  (L1_LINE_N),
    .L1_WAYS_N  (L1_WAYS_N),
    .L2_SIZE_N  (L2_SIZE_N),
    .L2_LINE_N  (L2_LINE_N),
    .L2_WAYS_N  (L2_WAYS_N),
    .MAX_TRIALS (MAX_TRIALS),
    .CNT_W      (CNT_W)
) i_chk (.*);

// File: tb/test_cache_tune_seq.sv
module test_cache_tune_seq;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 2;
    localparam int CNT_W      = 4;
    localparam int WATCHDOG   = 50000;
    localparam int LAST [6]   = '{2, 1, 2, 1, 2, 1};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             abort = 1'b0;
    logic             energy_valid = 1'b0;
    logic [31:0]      energy = '0;
    logic             eval_req;
    logic [IDX_W-1:0] l1_size, l1_line, l1_ways, l2_size, l2_line, l2_ways;
    logic             done;
    logic [CNT_W-1:0] eval_count;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cache_tune_seq i_cache_tune_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .abort        (abort),
        .energy_valid (energy_valid),
        .energy       (energy),
        .eval_req     (eval_req),
        .l1_size      (l1_size),
        .l1_line      (l1_line),
        .l1_ways      (l1_ways),
        .l2_size      (l2_size),
        .l2_line      (l2_line),
        .l2_ways      (l2_ways),
        .done         (done),
        .eval_count   (eval_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Fields packed 2 bits each in tuning order: l1s, l2s, l1l, l2l, l1w, l2w.
    function automatic int dut_pack();
        return int'(l1_size) | (int'(l2_size) << 2) | (int'(l1_line) << 4) |
               (int'(l2_line) << 6) | (int'(l1_ways) << 8) | (int'(l2_ways) << 10);
    endfunction

    function automatic int energy_of(input int sc, input int p);
        int tgt [6] = '{1, 1, 2, 0, 1, 1};
        int sum = 0;
        int sq  = 0;
        for (int i = 0; i < 6; i++) begin
            int f = (p >> (2 * i)) & 3;
            sum += f;
            sq  += (f - tgt[i]) * (f - tgt[i]);
        end
        case (sc)
            0:       return 1000 - 10 * sum;
            1:       return 100 + 10 * sum;
            2:       return 500;
            default: return 100 + 10 * sq;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_fails++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Full search against energy scenario sc; delay holds each answer back.
    task automatic run_tune(input int sc, input int delay, input int hand_cfg,
                            input int hand_trials);
        int seq [16];
        int m_cnt = 0;
        int f [6] = '{0, 0, 0, 0, 0, 0};
        int best;
        int pk;
        int n = 0;
        int guard = 0;
        // Reference search from the requirements (R3, R4, R5).
        pk = 0;
        seq[m_cnt++] = pk;
        best = energy_of(sc, pk);
        for (int s = 0; s < 6; s++) begin
            while (f[s] < LAST[s]) begin
                int e;
                f[s]++;
                pk = 0;
                for (int i = 0; i < 6; i++) pk |= f[i] << (2 * i);
                seq[m_cnt++] = pk;
                e = energy_of(sc, pk);
                if (e < best) best = e;
                else begin
                    f[s]--;
                    break;
                end
            end
        end
        pk = 0;
        for (int i = 0; i < 6; i++) pk |= f[i] << (2 * i);
        chk(pk == hand_cfg, "R4 reference final", pk, hand_cfg);

        pulse_start();
        chk(eval_req == 1'b1, "R2 request after start", int'(eval_req), 1);
        chk(dut_pack() == 0, "R2 first trial all smallest", dut_pack(), 0);
        chk(eval_count == '0, "R2 count cleared", int'(eval_count), 0);
        while (!done && guard < 2000) begin
            guard++;
            if (eval_req) begin
                int now = dut_pack();
                chk(n < m_cnt && now == seq[n], "R3 trial configuration", now,
                    (n < m_cnt) ? seq[n] : -1);
                for (int d = 0; d < delay; d++) begin
                    @(negedge clk);
                    chk(eval_req && dut_pack() == now, "R6 request held", dut_pack(), now);
                end
                energy_valid = 1'b1;
                energy = 32'(energy_of(sc, now));
                @(negedge clk);
                energy_valid = 1'b0;
                n++;
            end else begin
                @(negedge clk);
            end
        end
        chk(done == 1'b1, "R7 done raised", int'(done), 1);
        chk(eval_req == 1'b0, "R7 no request when done", int'(eval_req), 0);
        chk(n == m_cnt, "R5 trial count", n, m_cnt);
        chk(n == hand_trials, "R4 trial count by hand", n, hand_trials);
        chk(int'(eval_count) == n, "R9 eval_count", int'(eval_count), n);
        chk(n <= 10, "R10 trial budget", n, 10);
        chk(dut_pack() == hand_cfg, "R7 best configuration applied", dut_pack(), hand_cfg);
        // R6/R7: a stray strobe while done changes nothing.
        energy_valid = 1'b1;
        energy = 32'd0;
        @(negedge clk);
        energy_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(done == 1'b1 && dut_pack() == hand_cfg, "R7 done holds", dut_pack(), hand_cfg);
        chk(int'(eval_count) == n, "R6 strobe ignored when done", int'(eval_count), n);
    endtask

    task automatic test_reset();
        chk(dut_pack() == 0, "R1 fields zero", dut_pack(), 0);
        chk(eval_req == 1'b0, "R1 eval_req low", int'(eval_req), 0);
        chk(done == 1'b0, "R1 done low", int'(done), 0);
        chk(eval_count == '0, "R1 count zero", int'(eval_count), 0);
    endtask

    task automatic test_idle_strobe();
        energy_valid = 1'b1;
        energy = 32'd5;
        @(negedge clk);
        energy_valid = 1'b0;
        @(negedge clk);
        chk(eval_req == 1'b0 && eval_count == '0, "R6 strobe ignored when idle",
            int'(eval_count), 0);
    endtask

    task automatic test_abort_collide();
        int guard = 0;
        pulse_start();
        // Answer the base trial.
        energy_valid = 1'b1;
        energy = 32'd1000;
        @(negedge clk);
        energy_valid = 1'b0;
        while (!eval_req && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        chk(eval_req == 1'b1 && dut_pack() == 1, "R3 second trial raises l1 size",
            dut_pack(), 1);
        // Energy and abort in the same cycle: abort wins.
        energy_valid = 1'b1;
        energy = 32'd10;
        abort = 1'b1;
        @(negedge clk);
        energy_valid = 1'b0;
        abort = 1'b0;
        chk(eval_req == 1'b0 && done == 1'b0, "R8 idle after abort", int'(eval_req), 0);
        chk(dut_pack() == 0, "R8 fields cleared on abort", dut_pack(), 0);
        chk(int'(eval_count) == 1, "R8 collided energy not counted", int'(eval_count), 1);
        repeat (3) @(negedge clk);
        chk(eval_req == 1'b0 && done == 1'b0, "R8 stays idle", int'(eval_req), 0);
        // Start and abort together while idle.
        start = 1'b1;
        abort = 1'b1;
        @(negedge clk);
        start = 1'b0;
        abort = 1'b0;
        @(negedge clk);
        chk(eval_req == 1'b0, "R8 abort beats start", int'(eval_req), 0);
    endtask

    task automatic test_abort_done();
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(done == 1'b0 && dut_pack() == 0, "R8 abort from done", dut_pack(), 0);
    endtask

    task automatic test_start_ignored();
        pulse_start();
        energy_valid = 1'b1;
        energy = 32'd900;
        start = 1'b1;
        @(negedge clk);
        energy_valid = 1'b0;
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk(int'(eval_count) == 1, "R2 start ignored while running", int'(eval_count), 1);
        chk(dut_pack() == 1, "R2 search continues", dut_pack(), 1);
        test_abort_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_idle_strobe();
        // Quadratic bowl: mixed keep/undo, final (1,1,2,0,1,1).
        run_tune(3, 0, 1 | (1 << 2) | (2 << 4) | (0 << 6) | (1 << 8) | (1 << 10), 10);
        // Monotone decreasing: every field reaches its top (R5).
        run_tune(0, 2, 2 | (1 << 2) | (2 << 4) | (1 << 6) | (2 << 8) | (1 << 10), 10);
        // Monotone increasing: each first raise undone (R4).
        run_tune(1, 0, 0, 7);
        // Flat energy: equal is not an improvement (R4).
        run_tune(2, 1, 0, 7);
        test_abort_done();
        test_abort_collide();
        test_start_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule